// File: doc/BRIEF.md
# Trap and Boot Vector Sequencer

This block is the control sequencer that takes a small 8-bit processor core out of reset and into its exception handlers. While reset is held it keeps the core stopped, clears the working registers and loads the status byte with only the run bit set. Once reset is released it fetches the 16-bit boot vector from the top of memory and starts the core there. Memory is synchronous, so each vector byte arrives one clock after its address is presented.

During execution it watches the core's instruction-boundary strobe. At a boundary it may enter a trap. A non-maskable interrupt is edge-triggered and always wins. A maskable interrupt is taken only when the interrupt-disable flag is clear. A decoded break instruction is the third source. For each trap the sequencer pushes the return address into a separate push-only stack RAM. For the maskable interrupt and the break it also pushes the status byte. It then fetches the source's vector, loads the program counter and writes back a status byte with interrupt-disable set and the run bit set. When the core reaches a boundary with the run bit clear, the sequencer parks it in a halt state. Only an interrupt or a reset leaves that state.

Top module: `trap_vector_seq`

## Requirements
- R1: While reset is held, reg_clear and psr_load are 1, psr_value is 0x20 (bit 5 = run), and core_run, mem_rd and push_en are 0.
- R2: After reset release there are no pushes. The block reads 0xFFFC and then 0xFFFD, then pulses pc_load with pc_value = {byte@0xFFFD, byte@0xFFFC}, and psr_load stays 0. core_run rises in the following cycle.
- R3: A rising edge on nmi_in that is pending at an instruction boundary pushes next_pc[15:8] and then next_pc[7:0]. It then reads 0xFFFA/0xFFFB and loads the program counter from them.
- R4: A high irq_in at a boundary while status bit 2 (interrupt disable) is 0 pushes next_pc high byte, next_pc low byte and then the status byte. It then reads 0xFFFE/0xFFFF. When bit 2 is 1, the request produces no push and core_run stays 1.
- R5: brk_insn at a boundary pushes next_pc high byte, low byte, then status with bit 4 (break) set, and uses the 0xFFFE/0xFFFF vector.
- R6: With every trap pc_load there is a psr_load whose value is the captured status with bit 2 and bit 5 set. Bit 4 is also set for break and only for break.
- R7: When an NMI and an unmasked IRQ are both pending at the same boundary, the NMI is taken.
- R8: An NMI held high gives exactly one entry. A later boundary with no other request leaves core_run at 1 and produces no push.
- R9: A boundary with status bit 5 clear and no request drops core_run to 0 until an interrupt. A masked IRQ does not wake it. An unmasked IRQ wakes it through a normal entry with next_pc as the return address.
- R10: push_addr starts at 0 after reset, moves up by one per pushed byte, and wraps from STACK_DEPTH-1 to 0.
- R11: The program counter is loaded only in the cycle after both vector addresses have been presented with mem_rd high.
- R12: Requests are acted on only at a boundary (insn_done high). While core_run is 1 there is no push, read or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_in | input | 1 | Non-maskable interrupt, edge sensitive |
| irq_in | input | 1 | Maskable interrupt, level |
| insn_done | input | 1 | Core is at an instruction boundary |
| brk_insn | input | 1 | Finished instruction is a break |
| next_pc | input | 16 | Address of the next instruction (return address) |
| status_in | input | 8 | Live processor status byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one clock after the address |
| push_en | output | 1 | Stack push strobe |
| push_addr | output | SP_W | Stack RAM write address |
| push_data | output | 8 | Byte pushed |
| pc_load | output | 1 | Load program counter |
| pc_value | output | 16 | New program counter |
| psr_load | output | 1 | Load status byte |
| psr_value | output | 8 | New status byte |
| reg_clear | output | 1 | Clear A, X and Y |
| core_run | output | 1 | Core may fetch and execute |

## Verification
Some properties are checked by assertions on every cycle. These are the reset outputs and the rule that a running core never sees a push, read or load at the same time. They also cover the one-step stack pointer motion with wrap, the two preceding read cycles before each program counter load, the run bit in every status write, and the core resuming after a load. Other behaviour can only be shown by the bench's scenarios. This covers the byte order and contents of each push frame, the choice of vector per source, NMI priority over IRQ, the single entry for a held NMI, masking, and leaving the halt state.

// File: rtl/tseq_pkg.sv
// Shared types and constants for the trap and boot vector sequencer.
// Assumes status byte layout: bit 2 interrupt disable, bit 4 break, bit 5 run.
package tseq_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_RUN,
        ST_HALT,
        ST_PSH_HI,
        ST_PSH_LO,
        ST_PSH_PS,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_VEC_LD
    } tseq_state_t;

    typedef enum logic [1:0] {
        SRC_BOOT = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_IRQ  = 2'd2,
        SRC_BRK  = 2'd3
    } tseq_src_t;

    localparam int          PSR_I_BIT   = 2;
    localparam int          PSR_B_BIT   = 4;
    localparam int          PSR_RUN_BIT = 5;
    localparam logic [7:0]  PSR_AT_RESET = 8'h20;

endpackage

// File: rtl/tseq_nmi_latch.sv
// Rising-edge detector with a sticky pending flag for the non-maskable request.
// Assumes nmi_in is already synchronous to clk; ack clears the pending flag.
module tseq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic ack,
    output logic pend
);
    logic nmi_d;

    // Remember the previous level and hold a detected edge until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_d <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_d <= nmi_in;
            pend  <= (pend & ~ack) | (nmi_in & ~nmi_d);
        end
    end
endmodule

// File: rtl/tseq_arbiter.sv
// Fixed-priority choice among trap sources: NMI, then unmasked IRQ, then break.
// Assumes window is high only when a trap may start; brk_ok qualifies break.
module tseq_arbiter
    import tseq_pkg::*;
(
    input  logic      window,
    input  logic      brk_ok,
    input  logic      nmi_pend,
    input  logic      irq_in,
    input  logic      i_flag,
    input  logic      brk_insn,
    output logic      take,
    output tseq_src_t src,
    output logic      nmi_ack
);
    // Pick the highest-priority active source inside the window.
    always_comb begin
        take    = 1'b0;
        src     = SRC_BOOT;
        nmi_ack = 1'b0;
        if (window) begin
            if (nmi_pend) begin
                take    = 1'b1;
                src     = SRC_NMI;
                nmi_ack = 1'b1;
            end else if (irq_in && !i_flag) begin
                take = 1'b1;
                src  = SRC_IRQ;
            end else if (brk_ok && brk_insn) begin
                take = 1'b1;
                src  = SRC_BRK;
            end
        end
    end
endmodule

// File: rtl/tseq_stack_ptr.sv
// Push-only stack pointer: advances one slot per push and wraps at DEPTH.
// Assumes DEPTH >= 2; power-of-two depths use plain binary wrap.
module tseq_stack_ptr #(
    parameter int DEPTH = 64,
    parameter int W     = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] LAST = W'(DEPTH - 1);
    localparam bit           POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    logic [W-1:0] ptr_nxt;

    generate
        if (POW2) begin : g_pow2
            // Natural overflow provides the wrap.
            always_comb ptr_nxt = ptr + W'(1);
        end else begin : g_mod
            // Explicit wrap for non power-of-two depths.
            always_comb ptr_nxt = (ptr == LAST) ? '0 : ptr + W'(1);
        end
    endgenerate

    // Register the pointer, moving only on a push.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (step) ptr <= ptr_nxt;
    end
endmodule

// File: rtl/trap_vector_seq.sv
// Reset, interrupt and break sequencer for an 8-bit core with synchronous
// memory and a separate push-only stack RAM. Holds the core in reset, fetches
// the boot vector, and at instruction boundaries enters traps: pushes the
// return address (and status for IRQ/break), fetches the source vector in two
// one-cycle-latency reads and loads PC and status. Parks the core when the
// run bit is clear until an interrupt arrives.
module trap_vector_seq
    import tseq_pkg::*;
#(
    parameter int          STACK_DEPTH = 64,
    parameter logic [15:0] VEC_NMI     = 16'hFFFA,
    parameter logic [15:0] VEC_BOOT    = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ     = 16'hFFFE,
    localparam int         SP_W        = $clog2(STACK_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nmi_in,
    input  logic            irq_in,
    input  logic            insn_done,
    input  logic            brk_insn,
    input  logic [15:0]     next_pc,
    input  logic [7:0]      status_in,
    output logic            mem_rd,
    output logic [15:0]     mem_addr,
    input  logic [7:0]      mem_rdata,
    output logic            push_en,
    output logic [SP_W-1:0] push_addr,
    output logic [7:0]      push_data,
    output logic            pc_load,
    output logic [15:0]     pc_value,
    output logic            psr_load,
    output logic [7:0]      psr_value,
    output logic            reg_clear,
    output logic            core_run
);
    localparam logic [7:0] I_MASK   = 8'(1 << PSR_I_BIT);
    localparam logic [7:0] B_MASK   = 8'(1 << PSR_B_BIT);
    localparam logic [7:0] RUN_MASK = 8'(1 << PSR_RUN_BIT);

    tseq_state_t state;
    tseq_src_t   src_q;
    tseq_src_t   arb_src;
    logic [15:0] ret_q;
    logic [7:0]  stat_q;
    logic [7:0]  lo_q;
    logic        nmi_pend;
    logic        nmi_ack;
    logic        take;
    logic        window;
    logic [15:0] vec_base;
    logic [7:0]  brk_bit;

    tseq_nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_in (nmi_in),
        .ack    (nmi_ack),
        .pend   (nmi_pend)
    );

    // Traps may start at a boundary while running, or any cycle while halted.
    always_comb window = ((state == ST_RUN) && insn_done) || (state == ST_HALT);

    tseq_arbiter u_arb (
        .window   (window),
        .brk_ok   (state == ST_RUN),
        .nmi_pend (nmi_pend),
        .irq_in   (irq_in),
        .i_flag   (status_in[PSR_I_BIT]),
        .brk_insn (brk_insn),
        .take     (take),
        .src      (arb_src),
        .nmi_ack  (nmi_ack)
    );

    tseq_stack_ptr #(
        .DEPTH (STACK_DEPTH),
        .W     (SP_W)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (push_en),
        .ptr   (push_addr)
    );

    // Sequencer state and the values captured at trap entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RESET;
            src_q  <= SRC_BOOT;
            ret_q  <= '0;
            stat_q <= '0;
            lo_q   <= '0;
        end else begin
            case (state)
                ST_RESET:  state <= ST_VEC_LO;
                ST_RUN, ST_HALT: begin
                    if (take) begin
                        state  <= ST_PSH_HI;
                        src_q  <= arb_src;
                        ret_q  <= next_pc;
                        stat_q <= status_in;
                    end else if (state == ST_RUN && insn_done && !status_in[PSR_RUN_BIT]) begin
                        state <= ST_HALT;
                    end
                end
                ST_PSH_HI: state <= ST_PSH_LO;
                ST_PSH_LO: state <= (src_q == SRC_NMI) ? ST_VEC_LO : ST_PSH_PS;
                ST_PSH_PS: state <= ST_VEC_LO;
                ST_VEC_LO: state <= ST_VEC_HI;
                ST_VEC_HI: begin
                    state <= ST_VEC_LD;
                    lo_q  <= mem_rdata;
                end
                ST_VEC_LD: state <= ST_RUN;
                default:   state <= ST_RESET;
            endcase
        end
    end

    // Vector base for the source being served.
    always_comb begin
        case (src_q)
            SRC_BOOT: vec_base = VEC_BOOT;
            SRC_NMI:  vec_base = VEC_NMI;
            default:  vec_base = VEC_IRQ;
        endcase
    end

    // Break flag contribution, only for a software break.
    always_comb brk_bit = (src_q == SRC_BRK) ? B_MASK : 8'h00;

    // Memory read port: low vector byte then high vector byte.
    always_comb begin
        mem_rd   = (state == ST_VEC_LO) || (state == ST_VEC_HI);
        mem_addr = (state == ST_VEC_LO) ? vec_base :
                   (state == ST_VEC_HI) ? vec_base + 16'd1 : 16'h0000;
    end

    // Stack push port: return address high, low, then status.
    always_comb begin
        push_en   = (state == ST_PSH_HI) || (state == ST_PSH_LO) || (state == ST_PSH_PS);
        case (state)
            ST_PSH_HI: push_data = ret_q[15:8];
            ST_PSH_LO: push_data = ret_q[7:0];
            ST_PSH_PS: push_data = stat_q | brk_bit;
            default:   push_data = 8'h00;
        endcase
    end

    // Program counter and status write-back plus core control.
    always_comb begin
        pc_load   = (state == ST_VEC_LD);
        pc_value  = {mem_rdata, lo_q};
        reg_clear = (state == ST_RESET);
        psr_load  = (state == ST_RESET) || ((state == ST_VEC_LD) && (src_q != SRC_BOOT));
        psr_value = (state == ST_RESET) ? PSR_AT_RESET
                                        : (stat_q | I_MASK | RUN_MASK | brk_bit);
        core_run  = (state == ST_RUN);
    end

endmodule

// File: rtl/tseq_checker.sv
// Cycle-level properties of the trap sequencer ports; bound to the top module.
// Assumes the synchronous active-low reset is held for at least one clock.
module tseq_checker #(
    parameter int STACK_DEPTH = 64,
    parameter int SP_W        = $clog2(STACK_DEPTH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_rd,
    input logic            push_en,
    input logic [SP_W-1:0] push_addr,
    input logic            pc_load,
    input logic            psr_load,
    input logic [7:0]      psr_value,
    input logic            reg_clear,
    input logic            core_run
);
    localparam logic [SP_W-1:0] SP_LAST = SP_W'(STACK_DEPTH - 1);

    // R1: reset holds the core stopped with cleared registers and run-only status.
    assert_reset_hold_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_clear && psr_load && psr_value == 8'h20 &&
                    !mem_rd && !push_en && !core_run));

    // R12: a running core never overlaps with a push, read or load.
    assert_quiet_while_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |-> (!push_en && !mem_rd && !pc_load));

    // R10: one pushed byte moves the pointer by exactly one slot, with wrap.
    assert_sp_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (push_addr == (($past(push_addr) == SP_LAST) ? '0 : $past(push_addr) + SP_W'(1))));

    // R11: a PC load follows two consecutive vector read cycles.
    assert_load_after_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> ($past(mem_rd) && $past(mem_rd, 2)));

    // R6: every status write keeps the run bit set.
    assert_run_bit_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        psr_load |-> psr_value[5]);

    // R2: the core resumes in the cycle after the PC load.
    assert_resume_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> core_run);

endmodule

bind trap_vector_seq tseq_checker #(.STACK_DEPTH(STACK_DEPTH)) u_tseq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .push_en   (push_en),
    .push_addr (push_addr),
    .pc_load   (pc_load),
    .psr_load  (psr_load),
    .psr_value (psr_value),
    .reg_clear (reg_clear),
    .core_run  (core_run)
);

// File: tb/trap_vector_seq_tb.sv
`timescale 1ns/1ps
module trap_vector_seq_tb;
    localparam int DEPTH = 64;
    localparam int SP_W  = $clog2(DEPTH);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            nmi_in = 1'b0, irq_in = 1'b0, insn_done = 1'b0, brk_insn = 1'b0;
    logic [15:0]     next_pc = 16'h0;
    logic [7:0]      status_in = 8'h20;
    logic            mem_rd, push_en, pc_load, psr_load, reg_clear, core_run;
    logic [15:0]     mem_addr, pc_value;
    logic [7:0]      mem_rdata = 8'h00, push_data, psr_value;
    logic [SP_W-1:0] push_addr;

    trap_vector_seq #(.STACK_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_in(irq_in),
        .insn_done(insn_done), .brk_insn(brk_insn), .next_pc(next_pc),
        .status_in(status_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .push_en(push_en), .push_addr(push_addr),
        .push_data(push_data), .pc_load(pc_load), .pc_value(pc_value),
        .psr_load(psr_load), .psr_value(psr_value), .reg_clear(reg_clear),
        .core_run(core_run)
    );

    // Synchronous memory model: vector bytes at 0xFFFA..0xFFFF.
    logic [7:0] vrom [6];
    always_ff @(posedge clk)
        if (mem_rd) mem_rdata <= (mem_addr >= 16'hFFFA) ? vrom[mem_addr - 16'hFFFA] : 8'hEE;

    int checks = 0, fails = 0, sp_exp = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Trace of one entry.
    logic [7:0]      pd [4];
    logic [SP_W-1:0] pa [4];
    logic [15:0]     ra [4];
    int              np, nr;
    logic            got_pc, psrl;
    logic [15:0]     pcv;
    logic [7:0]      psrv;

    task automatic new_rom();
        for (int k = 0; k < 6; k++) vrom[k] = 8'($urandom);
    endtask

    task automatic collect();
        np = 0; nr = 0; got_pc = 1'b0; psrl = 1'b0; pcv = '0; psrv = '0;
        for (int i = 0; i < 14 && !got_pc; i++) begin
            @(negedge clk);
            if (push_en) begin
                if (np < 4) begin pd[np] = push_data; pa[np] = push_addr; end
                np++;
            end
            if (mem_rd) begin
                if (nr < 4) ra[nr] = mem_addr;
                nr++;
            end
            if (pc_load) begin
                got_pc = 1'b1; pcv = pc_value; psrl = psr_load; psrv = psr_value;
            end
            insn_done = 1'b0;
            brk_insn  = 1'b0;
        end
        irq_in = 1'b0;
    endtask

    // kind: 0 boot, 1 nmi, 2 irq, 3 break
    task automatic check_entry(input string req, input int kind, input logic [15:0] ret, input logic [7:0] st);
        logic [7:0]  exp_d [3];
        int          nexp;
        logic [15:0] base;
        nexp = (kind == 0) ? 0 : (kind == 1) ? 2 : 3;
        exp_d[0] = ret[15:8];
        exp_d[1] = ret[7:0];
        exp_d[2] = (kind == 3) ? (st | 8'h10) : st;
        base = (kind == 0) ? 16'hFFFC : (kind == 1) ? 16'hFFFA : 16'hFFFE;
        chk(req, "push count", np, nexp);
        for (int j = 0; j < nexp && j < np; j++) begin
            chk(req, "push data", pd[j], exp_d[j]);
            chk(req, "push addr", pa[j], sp_exp);
            sp_exp = (sp_exp + 1) % DEPTH;
        end
        chk(req, "read count", nr, 2);
        chk(req, "read lo addr", ra[0], base);
        chk(req, "read hi addr", ra[1], base + 16'd1);
        chk(req, "pc loaded", got_pc, 1);
        chk(req, "pc value", pcv, {vrom[base - 16'hFFFA + 16'd1], vrom[base - 16'hFFFA]});
        if (kind == 0) chk(req, "psr load", psrl, 0);
        else begin
            chk(req, "psr load", psrl, 1);
            chk("R6", "psr value", psrv, st | 8'h24 | ((kind == 3) ? 8'h10 : 8'h00));
        end
    endtask

    task automatic boundary(input logic arm_nmi, input logic irq_v, input logic brk_v,
                            input logic [7:0] st, input logic [15:0] ret);
        new_rom();
        if (arm_nmi) begin
            @(negedge clk); nmi_in = 1'b1;
        end
        @(negedge clk);
        status_in = st; next_pc = ret; irq_in = irq_v; brk_insn = brk_v; insn_done = 1'b1;
        collect();
    endtask

    // Boundary that must not start a trap.
    task automatic quiet_boundary(input string req, input logic irq_v, input logic [7:0] st);
        @(negedge clk);
        status_in = st; irq_in = irq_v; insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk(req, "no push", push_en, 0);
        chk(req, "still running", core_run, 1);
        irq_in = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  st;
        logic [15:0] ret;
        void'($urandom(32'd20240611));
        new_rom();
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "reg_clear", reg_clear, 1);
        chk("R1", "psr_load", psr_load, 1);
        chk("R1", "psr_value", psr_value, 8'h20);
        chk("R1", "core_run", core_run, 0);
        chk("R1", "mem_rd", mem_rd, 0);
        chk("R1", "push_en", push_en, 0);
        // R2: boot vector fetch
        rst_n = 1'b1;
        collect();
        check_entry("R2", 0, 16'h0, 8'h0);
        @(negedge clk);
        chk("R2", "run after boot", core_run, 1);

        // R12: request without boundary does nothing
        status_in = 8'h20; irq_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R12", "no push mid-insn", push_en, 0);
            chk("R12", "running mid-insn", core_run, 1);
        end
        insn_done = 1'b1; next_pc = 16'hA55A; new_rom();
        collect();
        check_entry("R4", 2, 16'hA55A, 8'h20);

        // R4: masked IRQ is ignored
        quiet_boundary("R4", 1'b1, 8'h24);

        // R7: NMI wins over IRQ; R3 frame
        boundary(1'b1, 1'b1, 1'b0, 8'h21, 16'h1357);
        check_entry("R7", 1, 16'h1357, 8'h21);
        // R8: held NMI gives no second entry
        quiet_boundary("R8", 1'b0, 8'h20);
        @(negedge clk); nmi_in = 1'b0;

        // R5: break frame
        boundary(1'b0, 1'b0, 1'b1, 8'hC3, 16'h1234);
        check_entry("R5", 3, 16'h1234, 8'hC3);

        // R9: halt, masked IRQ keeps it, unmasked IRQ wakes it
        @(negedge clk);
        status_in = 8'h00; insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk("R9", "halted", core_run, 0);
        status_in = 8'h04; irq_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", "masked stays halted", core_run, 0);
            chk("R9", "masked no push", push_en, 0);
        end
        new_rom();
        status_in = 8'h00; next_pc = 16'h4567;
        collect();
        check_entry("R9", 2, 16'h4567, 8'h00);

        // Random mix; also drives the stack pointer through its wrap (R10).
        for (int it = 0; it < 60; it++) begin
            int k;
            k   = $urandom_range(0, 4);
            st  = (8'($urandom) & 8'hCB) | 8'h20;
            ret = 16'($urandom);
            case (k)
                0: begin boundary(1'b1, 1'b0, 1'b0, st, ret); check_entry("R3", 1, ret, st); end
                1: begin boundary(1'b0, 1'b1, 1'b0, st, ret); check_entry("R4", 2, ret, st); end
                2: begin boundary(1'b0, 1'b0, 1'b1, st, ret); check_entry("R10", 3, ret, st); end
                3: begin boundary(1'b1, 1'b1, 1'b1, st, ret); check_entry("R7", 1, ret, st); end
                default: quiet_boundary("R4", 1'b1, st | 8'h04);
            endcase
            @(negedge clk); nmi_in = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule